// File: doc/BRIEF.md
# Predicated matrix-slot instruction decoder

This block takes one 64-bit slot word from an instruction bundle and turns it into a command for a matrix multiply unit. From fixed fields of the word it takes an operation code, the number of the target unit and a predicate. It sorts the operation code into one of three command families: multiply steps, weight latches and the reduce/permute group, which contains the transposes. It works out the sub-kind of the command within its family and decides whether the command issues. That decision reads a small file of predicate registers.

The decoded command is registered and appears on the clock edge that follows a valid input. A command issues only when the operation code and the unit number are both legal and the predicate evaluates true. A slot whose predicate is the reserved never-execute value is an empty slot. It gives no command and raises no error.

Top module: `mxslot_decoder`

## Requirements
- R1: The unit number is taken from slot bits 28:27, the operation code from bits 34:29 and the predicate from bits 39:35. No other bit of the slot word affects any output.
- R2: Codes 0 to 6 decode as family 0 (multiply). Sub-kind 0 is a full step (codes 0 and 4), 1 is a low-half step (1 and 5), 2 is a high-half step (2 and 6) and 3 is the staging-only step (code 3). The transpose flag is 1 for codes 0, 1 and 2 and 0 for codes 3 to 6.
- R3: The uses-data output is 0 for code 3 and for illegal codes. It is 1 for every other legal code.
- R4: Codes 7 to 12 decode as family 1 (weight latch) with the transpose flag at 0. The sub-kind is the latch mode m, where modes 0, 1, 2, 3, 4 and 5 are carried by codes 7, 10, 9, 12, 8 and 11.
- R5: Codes 17 to 34 decode as family 2 (reduce/permute) with sub-kind equal to the code minus 17. The transpose flag is 1 only for codes 17 and 18.
- R6: Codes 13 to 16 and 35 to 63 are illegal. An illegal code gives family 3, sub-kind 0, transpose 0, illegal 1 and valid 0, whatever the predicate.
- R7: When the low four predicate bits n are 0 to 14, the predicate value is predicate register n, inverted when predicate bit 4 is set. A legal command is valid exactly when this value is 1.
- R8: Predicate 15 always issues a legal command. Predicate 31 never issues and marks an empty slot, which reports illegal 0 when the code and unit are legal.
- R9: The unit number is always reported. With MULTI_UNIT=0 a nonzero unit number sets illegal and clears valid, while the other fields are still reported. With MULTI_UNIT=1 all four unit numbers are legal.
- R10: Outputs change on the rising edge after the input is sampled. If the input valid is low at an edge, valid and illegal are 0 after that edge. The active-low reset clears valid and illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Slot word present this cycle |
| slot_i | input | 64 | Slot word |
| preg_i | input | 15 | Predicate register file, bit n is register n |
| cmd_valid_o | output | 1 | Command issues |
| cmd_family_o | output | 2 | 0 multiply, 1 latch, 2 reduce/permute, 3 none |
| cmd_kind_o | output | 5 | Sub-kind within the family |
| cmd_xpose_o | output | 1 | Transposed form |
| cmd_data_o | output | 1 | Command consumes data operands |
| cmd_unit_o | output | 2 | Target unit number |
| cmd_illegal_o | output | 1 | Illegal code or unit number |

## Verification
The bench sweeps all 64 operation codes against all four unit numbers on a single-unit instance and a multi-unit instance at the same time. This separates the family boundaries, the permuted latch modes and the unit-legality rule, and the unused slot bits are held at a non-zero filler pattern. It then sweeps all 32 predicate codes against predicate files of alternating, all-zero, all-one and walking-bit contents. This separates register selection from the negate bit and from the two reserved codes. Idle cycles, an empty slot carrying an illegal code, and a reset asserted in the middle of the run check the timing and the clearing of valid.

// File: rtl/mxslot_pkg.sv
package mxslot_pkg;

  typedef enum logic [1:0] {
    FAM_MATMUL = 2'd0,
    FAM_LATCH  = 2'd1,
    FAM_XFORM  = 2'd2,
    FAM_NONE   = 2'd3
  } fam_e;

  localparam int unsigned MM_LAST     = 6;
  localparam int unsigned STAGE_OP    = 3;
  localparam int unsigned LATCH_MODES = 6;
  localparam int unsigned LATCH_FIRST = 7;
  localparam int unsigned LATCH_LAST  = 12;
  localparam int unsigned XF_FIRST    = 17;
  localparam int unsigned XF_LAST     = 34;
  localparam int unsigned XP_LAST     = 18;

  // forward latch-mode -> opcode table; the decoder inverts it
  function automatic int unsigned latch_op_of(input int unsigned mode);
    case (mode)
      0:       latch_op_of = 7;
      1:       latch_op_of = 10;
      2:       latch_op_of = 9;
      3:       latch_op_of = 12;
      4:       latch_op_of = 8;
      5:       latch_op_of = 11;
      default: latch_op_of = 0;
    endcase
  endfunction

endpackage

// File: rtl/mxslot_opclass.sv
module mxslot_opclass
  import mxslot_pkg::*;
#(
  parameter int unsigned OP_W   = 6,
  parameter int unsigned KIND_W = 5
) (
  input  logic [OP_W-1:0]   op_i,
  output fam_e              fam_o,
  output logic [KIND_W-1:0] kind_o,
  output logic              xpose_o,
  output logic              data_o,
  output logic              bad_o
);

  logic [31:0] opv;
  assign opv = {{(32-OP_W){1'b0}}, op_i};

  always_comb begin
    fam_o   = FAM_NONE;
    kind_o  = '0;
    xpose_o = 1'b0;
    data_o  = 1'b0;
    bad_o   = 1'b1;
    if (opv <= MM_LAST) begin
      fam_o   = FAM_MATMUL;
      bad_o   = 1'b0;
      data_o  = (opv != STAGE_OP);
      kind_o  = KIND_W'(opv[1:0]);
      xpose_o = (opv < STAGE_OP);
    end else if (opv >= LATCH_FIRST && opv <= LATCH_LAST) begin
      fam_o  = FAM_LATCH;
      bad_o  = 1'b0;
      data_o = 1'b1;
      for (int unsigned m = 0; m < LATCH_MODES; m++) begin
        if (opv == latch_op_of(m)) kind_o = KIND_W'(m);
      end
    end else if (opv >= XF_FIRST && opv <= XF_LAST) begin
      fam_o   = FAM_XFORM;
      bad_o   = 1'b0;
      data_o  = 1'b1;
      kind_o  = KIND_W'(opv - XF_FIRST);
      xpose_o = (opv <= XP_LAST);
    end
  end

endmodule

// File: rtl/mxslot_pred_eval.sv
module mxslot_pred_eval #(
  parameter int unsigned PRED_W   = 5,
  parameter int unsigned NUM_PREG = 15
) (
  input  logic [PRED_W-1:0]   pred_i,
  input  logic [NUM_PREG-1:0] preg_i,
  output logic                fire_o
);

  localparam int unsigned SEL_W = PRED_W - 1;
  localparam int unsigned SLOTS = 1 << SEL_W;

  logic [SLOTS-1:0] ext;

  // indices past the file read as 1: always when plain, never when negated
  for (genvar g = 0; g < SLOTS; g++) begin : g_ext
    if (g < NUM_PREG) begin : g_reg
      assign ext[g] = preg_i[g];
    end else begin : g_rsv
      assign ext[g] = 1'b1;
    end
  end

  assign fire_o = ext[pred_i[SEL_W-1:0]] ^ pred_i[PRED_W-1];

endmodule

// File: rtl/mxslot_decoder.sv
module mxslot_decoder
  import mxslot_pkg::*;
#(
  parameter int unsigned WORD_W     = 64,
  parameter int unsigned UNIT_LSB   = 27,
  parameter int unsigned UNIT_W     = 2,
  parameter int unsigned OP_LSB     = 29,
  parameter int unsigned OP_W       = 6,
  parameter int unsigned PRED_LSB   = 35,
  parameter int unsigned PRED_W     = 5,
  parameter int unsigned NUM_PREG   = 15,
  parameter int unsigned KIND_W     = 5,
  parameter bit          MULTI_UNIT = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [WORD_W-1:0]   slot_i,
  input  logic [NUM_PREG-1:0] preg_i,
  output logic                cmd_valid_o,
  output logic [1:0]          cmd_family_o,
  output logic [KIND_W-1:0]   cmd_kind_o,
  output logic                cmd_xpose_o,
  output logic                cmd_data_o,
  output logic [UNIT_W-1:0]   cmd_unit_o,
  output logic                cmd_illegal_o
);

  logic [UNIT_W-1:0] unit;
  logic [OP_W-1:0]   op;
  logic [PRED_W-1:0] pred;

  assign unit = slot_i[UNIT_LSB +: UNIT_W];
  assign op   = slot_i[OP_LSB +: OP_W];
  assign pred = slot_i[PRED_LSB +: PRED_W];

  fam_e              fam;
  logic [KIND_W-1:0] kind;
  logic              xpose, data, op_bad, unit_bad, fire;

  mxslot_opclass #(.OP_W(OP_W), .KIND_W(KIND_W)) u_opclass (
    .op_i    (op),
    .fam_o   (fam),
    .kind_o  (kind),
    .xpose_o (xpose),
    .data_o  (data),
    .bad_o   (op_bad)
  );

  mxslot_pred_eval #(.PRED_W(PRED_W), .NUM_PREG(NUM_PREG)) u_pred (
    .pred_i (pred),
    .preg_i (preg_i),
    .fire_o (fire)
  );

  if (MULTI_UNIT) begin : g_multi
    assign unit_bad = 1'b0;
  end else begin : g_single
    assign unit_bad = |unit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o   <= 1'b0;
      cmd_illegal_o <= 1'b0;
      cmd_family_o  <= FAM_NONE;
      cmd_kind_o    <= '0;
      cmd_xpose_o   <= 1'b0;
      cmd_data_o    <= 1'b0;
      cmd_unit_o    <= '0;
    end else begin
      cmd_valid_o   <= in_valid_i & ~op_bad & ~unit_bad & fire;
      cmd_illegal_o <= in_valid_i & (op_bad | unit_bad);
      if (in_valid_i) begin
        cmd_family_o <= fam;
        cmd_kind_o   <= kind;
        cmd_xpose_o  <= xpose;
        cmd_data_o   <= data;
        cmd_unit_o   <= unit;
      end
    end
  end

endmodule

// File: rtl/mxslot_decoder_chk.sv
module mxslot_decoder_chk #(
  parameter int unsigned WORD_W     = 64,
  parameter int unsigned UNIT_LSB   = 27,
  parameter int unsigned UNIT_W     = 2,
  parameter int unsigned PRED_LSB   = 35,
  parameter int unsigned PRED_W     = 5,
  parameter int unsigned KIND_W     = 5,
  parameter bit          MULTI_UNIT = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [WORD_W-1:0] slot_i,
  input logic              cmd_valid_o,
  input logic [1:0]        cmd_family_o,
  input logic [KIND_W-1:0] cmd_kind_o,
  input logic              cmd_xpose_o,
  input logic [UNIT_W-1:0] cmd_unit_o,
  input logic              cmd_illegal_o
);

  localparam logic [PRED_W-1:0] PRED_ALWAYS = PRED_W'((1 << (PRED_W-1)) - 1);
  localparam logic [PRED_W-1:0] PRED_NEVER  = '1;

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !cmd_illegal_o);

  p_valid_family_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_family_o != 2'd3);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!cmd_valid_o && !cmd_illegal_o));

  p_never_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && slot_i[PRED_LSB +: PRED_W] == PRED_NEVER) |=> !cmd_valid_o);

  p_always_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && slot_i[PRED_LSB +: PRED_W] == PRED_ALWAYS) |=> (cmd_valid_o || cmd_illegal_o));

  p_unit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> cmd_unit_o == $past(slot_i[UNIT_LSB +: UNIT_W]));

  p_latch_kind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_family_o == 2'd1) |-> (cmd_kind_o < KIND_W'(6) && !cmd_xpose_o));

  if (!MULTI_UNIT) begin : g_single
    p_single_unit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_o |-> cmd_unit_o == '0);
  end

endmodule

bind mxslot_decoder mxslot_decoder_chk #(
  .WORD_W(WORD_W), .UNIT_LSB(UNIT_LSB), .UNIT_W(UNIT_W), .PRED_LSB(PRED_LSB),
  .PRED_W(PRED_W), .KIND_W(KIND_W), .MULTI_UNIT(MULTI_UNIT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .slot_i        (slot_i),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_family_o  (cmd_family_o),
  .cmd_kind_o    (cmd_kind_o),
  .cmd_xpose_o   (cmd_xpose_o),
  .cmd_unit_o    (cmd_unit_o),
  .cmd_illegal_o (cmd_illegal_o)
);

// File: tb/tb_mxslot_decoder.sv
module tb_mxslot_decoder;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FILL = 64'hA5A5_5A5A_C3C3_3C3C;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [63:0] slot_i = '0;
  logic [14:0] preg_i = '0;

  logic       s_valid, s_xpose, s_data, s_illegal;
  logic [1:0] s_family, s_unit;
  logic [4:0] s_kind;
  logic       m_valid, m_xpose, m_data, m_illegal;
  logic [1:0] m_family, m_unit;
  logic [4:0] m_kind;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxslot_decoder #(.MULTI_UNIT(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .slot_i(slot_i), .preg_i(preg_i),
    .cmd_valid_o(s_valid), .cmd_family_o(s_family), .cmd_kind_o(s_kind), .cmd_xpose_o(s_xpose),
    .cmd_data_o(s_data), .cmd_unit_o(s_unit), .cmd_illegal_o(s_illegal)
  );

  mxslot_decoder #(.MULTI_UNIT(1'b1)) dut_multi (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .slot_i(slot_i), .preg_i(preg_i),
    .cmd_valid_o(m_valid), .cmd_family_o(m_family), .cmd_kind_o(m_kind), .cmd_xpose_o(m_xpose),
    .cmd_data_o(m_data), .cmd_unit_o(m_unit), .cmd_illegal_o(m_illegal)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mk(input int op, input int unit, input int pred);
    logic [63:0] s;
    s = FILL;
    s[28:27] = 2'(unit);
    s[34:29] = 6'(op);
    s[39:35] = 5'(pred);
    return s;
  endfunction

  task automatic apply(input bit v, input logic [63:0] s, input logic [14:0] p);
    @(negedge clk);
    in_valid_i = v;
    slot_i = s;
    preg_i = p;
    @(posedge clk);
    #1;
  endtask

  // expected decode from the opcode rules
  task automatic expect_op(input int op, output int fam, output int kind, output int xp,
                           output int dat, output int bad);
    int lat [6] = '{7, 10, 9, 12, 8, 11};
    fam = 3; kind = 0; xp = 0; dat = 0; bad = 1;
    if (op <= 6) begin
      fam = 0; bad = 0;
      dat = (op != 3) ? 1 : 0;
      kind = (op == 3) ? 3 : op % 4;
      xp = (op < 3) ? 1 : 0;
    end else if (op >= 7 && op <= 12) begin
      fam = 1; bad = 0; dat = 1;
      for (int m = 0; m < 6; m++) if (lat[m] == op) kind = m;
    end else if (op >= 17 && op <= 34) begin
      fam = 2; bad = 0; dat = 1;
      kind = op - 17;
      xp = (op <= 18) ? 1 : 0;
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int fam, kind, xp, dat, bad;
    logic [14:0] pats [6];
    pats = '{15'h0000, 15'h7FFF, 15'h5555, 15'h2AAA, 15'h0001, 15'h4000};

    // R10 reset state
    #(CLK_PERIOD*2 + 1);
    chk("R10", "reset valid", int'(s_valid), 0);
    chk("R10", "reset illegal", int'(s_illegal), 0);
    chk("R10", "reset valid multi", int'(m_valid), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 R2 R3 R4 R5 R6 R9: full code x unit sweep, always-execute predicate
    for (int op = 0; op < 64; op++) begin
      for (int u = 0; u < 4; u++) begin
        apply(1'b1, mk(op, u, 15), 15'h0);
        expect_op(op, fam, kind, xp, dat, bad);
        chk("R2_R4_R5", "family", int'(s_family), fam);
        chk("R2_R4_R5", "kind", int'(s_kind), kind);
        chk("R2_R5", "xpose", int'(s_xpose), xp);
        chk("R3", "data", int'(s_data), dat);
        chk("R1_R9", "unit", int'(s_unit), u);
        chk("R6_R9", "illegal single", int'(s_illegal), (bad || u != 0) ? 1 : 0);
        chk("R6_R8_R9", "valid single", int'(s_valid), (bad || u != 0) ? 0 : 1);
        chk("R2_R4_R5", "family multi", int'(m_family), fam);
        chk("R2_R4_R5", "kind multi", int'(m_kind), kind);
        chk("R1_R9", "unit multi", int'(m_unit), u);
        chk("R6_R9", "illegal multi", int'(m_illegal), bad);
        chk("R6_R8_R9", "valid multi", int'(m_valid), bad ? 0 : 1);
      end
    end

    // R7 R8: predicate sweep against several register files
    for (int pi = 0; pi < 6; pi++) begin
      for (int pr = 0; pr < 32; pr++) begin
        int low, neg, fire;
        low = pr % 16;
        neg = pr / 16;
        if (low == 15) fire = (neg == 0) ? 1 : 0;
        else fire = int'(pats[pi][low]) ^ neg;
        apply(1'b1, mk(5, 0, pr), pats[pi]);
        chk("R7_R8", "pred valid", int'(s_valid), fire);
        chk("R8", "pred illegal", int'(s_illegal), 0);
        chk("R7_R8", "pred valid multi", int'(m_valid), fire);
      end
    end

    // R6: illegal code in an empty slot still flags illegal
    apply(1'b1, mk(13, 0, 31), 15'h7FFF);
    chk("R6", "illegal empty", int'(s_illegal), 1);
    chk("R6", "valid empty illegal", int'(s_valid), 0);
    chk("R6", "family none", int'(s_family), 3);

    // R10: idle cycle clears valid and illegal
    apply(1'b1, mk(4, 0, 15), 15'h0);
    chk("R10", "valid before idle", int'(s_valid), 1);
    apply(1'b0, mk(4, 0, 15), 15'h0);
    chk("R10", "idle valid", int'(s_valid), 0);
    chk("R10", "idle illegal", int'(s_illegal), 0);
    apply(1'b0, mk(40, 0, 15), 15'h0);
    chk("R10", "idle illegal code", int'(s_illegal), 0);

    // R10: asynchronous reset mid-run
    apply(1'b1, mk(20, 0, 15), 15'h0);
    chk("R5", "valid before reset", int'(s_valid), 1);
    #2;
    rst_ni = 1'b0;
    #1;
    chk("R10", "async reset valid", int'(s_valid), 0);
    chk("R10", "async reset valid multi", int'(m_valid), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    report();
  end

endmodule